// File: doc/BRIEF.md
# Folded Single-Port SRAM Array

This block is a synthesizable behavioural model of a 2048-word by 16-bit single-port memory whose storage is laid out as a wide array of 256 rows of 128 cells. Each word address is split into two fields. The upper field picks one row through a two-level decoder: two 4-to-16 one-hot predecoders feed a final AND per row. The lower field picks one of eight column groups. A read gathers the word from the selected row through one 8:1 selector per data bit. A write rewrites only the 16 cells of the addressed word and leaves the rest of the row unchanged.

Each clock cycle performs one read, one write, or nothing. A cycle without an access is the bitline precharge phase of the access sequence, and no wordline is raised during it. Read data is registered, appears one cycle after the request, and holds until the next read completes.

Top module: `sram_folded`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `rdata` is 0.
- R2: A cycle with `ce`=1 and `we`=0 puts the word stored at `addr` on `rdata` after the next rising clock edge.
- R3: A cycle with `ce`=1 and `we`=1 stores `wdata` at `addr`, and a later read of that address returns it.
- R4: A write leaves every other word unchanged. This includes the seven other words of the same row, which differ only in `addr[2:0]`, and the words in other rows that share the same column group.
- R5: `addr[10:3]` selects the row and `addr[2:0]` the column group. During an enabled access exactly one wordline is raised, so all 2048 addresses hold distinct, independent words.
- R6: When `ce`=0 nothing is stored, whatever `we`, `addr` and `wdata` carry. This is the precharge phase, no wordline is raised, and `rdata` keeps its value.
- R7: A write cycle does not change `rdata`.
- R8: The lowest address (0) and the highest address (2047) store and return data like any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read data register |
| ce | input | 1 | Chip enable; 1 performs an access this cycle |
| we | input | 1 | Write enable; 1 writes and 0 reads when `ce` is 1 |
| addr | input | 11 | Word address: bits 10..3 are the row, bits 2..0 the column group |
| wdata | input | 16 | Data to store on a write |
| rdata | output | 16 | Registered read data, valid one cycle after a read |

## Verification
The memory is first filled with a pattern that differs for every address. Every address is then read back, so a wrong row or column split, or a decoder that raises two rows, shows up as aliased data. A targeted write into the middle of one row is followed by reads of its seven row neighbours and of the same column group in the rows above and below, which tells a correct per-word merge apart from a write that smears across the row or the column. Disabled cycles with `we` high and write cycles after a read separate a store that is properly gated by `ce` and a read register that holds from ones that leak. The two extreme addresses check that the field split is correct at its ends.

// File: rtl/sram_fold_pkg.sv
package sram_fold_pkg;

  // Access phase of one cycle; idle cycles model bitline precharge.
  typedef enum logic [1:0] {
    PH_PRECHARGE = 2'd0,
    PH_READ      = 2'd1,
    PH_WRITE     = 2'd2
  } phase_e;

  // Physical column of data bit 'bit_i' when column group 'grp' is chosen.
  function automatic int unsigned phys_col(input int unsigned bit_i,
                                           input int unsigned grp,
                                           input int unsigned col_bits);
    return (bit_i << col_bits) + grp;
  endfunction

  // Row field of a word address.
  function automatic int unsigned row_field(input int unsigned word_addr,
                                            input int unsigned col_bits);
    return word_addr >> col_bits;
  endfunction

endpackage

// File: rtl/sram_predec.sv
module sram_predec #(
  parameter int unsigned IN_W = 4
) (
  input  logic                  en,
  input  logic [IN_W-1:0]       sel,
  output logic [(1<<IN_W)-1:0]  line
);
  localparam int unsigned OUT_N = 1 << IN_W;

  genvar g;
  generate
    for (g = 0; g < OUT_N; g++) begin : g_line
      assign line[g] = en && (sel == IN_W'(g));
    end
  endgenerate
endmodule

// File: rtl/sram_row_dec.sv
module sram_row_dec #(
  parameter int unsigned ROW_BITS = 8
) (
  input  logic                      en,
  input  logic [ROW_BITS-1:0]       row,
  output logic [(1<<ROW_BITS)-1:0]  wl
);
  localparam int unsigned LO_BITS = ROW_BITS / 2;
  localparam int unsigned HI_BITS = ROW_BITS - LO_BITS;
  localparam int unsigned ROWS    = 1 << ROW_BITS;
  localparam int unsigned LO_N    = 1 << LO_BITS;

  logic [LO_N-1:0]         lo_line;
  logic [(1<<HI_BITS)-1:0] hi_line;

  sram_predec #(.IN_W(LO_BITS)) u_pre_lo (
    .en  (en),
    .sel (row[LO_BITS-1:0]),
    .line(lo_line)
  );

  sram_predec #(.IN_W(HI_BITS)) u_pre_hi (
    .en  (en),
    .sel (row[ROW_BITS-1:LO_BITS]),
    .line(hi_line)
  );

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_wl
      assign wl[r] = hi_line[r / LO_N] && lo_line[r % LO_N];
    end
  endgenerate
endmodule

// File: rtl/sram_col_path.sv
module sram_col_path
  import sram_fold_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned COL_BITS = 3
) (
  input  logic [(WORD_W<<COL_BITS)-1:0] row_q,
  input  logic [COL_BITS-1:0]           col,
  input  logic [WORD_W-1:0]             wdata,
  output logic [WORD_W-1:0]             rd_word,
  output logic [(WORD_W<<COL_BITS)-1:0] row_d
);
  localparam int unsigned GROUP = 1 << COL_BITS;

  // One GROUP:1 selector per data bit; bit i sits in columns i*GROUP .. i*GROUP+GROUP-1.
  genvar i;
  generate
    for (i = 0; i < WORD_W; i++) begin : g_bit
      logic [GROUP-1:0] slice;
      assign slice      = row_q[i*GROUP +: GROUP];
      assign rd_word[i] = slice[col];
    end
  endgenerate

  // Write steering: replace only the addressed cell of each bit group.
  always_comb begin
    row_d = row_q;
    for (int b = 0; b < WORD_W; b++) begin
      row_d[phys_col(b, int'(col), COL_BITS)] = wdata[b];
    end
  end
endmodule

// File: rtl/sram_folded.sv
module sram_folded
  import sram_fold_pkg::*;
#(
  parameter int unsigned ROW_BITS = 8,
  parameter int unsigned COL_BITS = 3,
  parameter int unsigned WORD_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ce,
  input  logic                         we,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic [WORD_W-1:0]            wdata,
  output logic [WORD_W-1:0]            rdata
);
  localparam int unsigned ADDR_W = ROW_BITS + COL_BITS;
  localparam int unsigned ROWS   = 1 << ROW_BITS;
  localparam int unsigned ROW_W  = WORD_W << COL_BITS;

  logic [ROW_BITS-1:0] row_sel;
  logic [COL_BITS-1:0] col_sel;
  assign row_sel = addr[ADDR_W-1:COL_BITS];
  assign col_sel = addr[COL_BITS-1:0];

  phase_e phase;
  logic   access_rd;
  logic   access_wr;
  always_comb begin
    if (!ce)     phase = PH_PRECHARGE;
    else if (we) phase = PH_WRITE;
    else         phase = PH_READ;
  end
  assign access_rd = (phase == PH_READ);
  assign access_wr = (phase == PH_WRITE);

  logic [ROWS-1:0] wl;
  sram_row_dec #(.ROW_BITS(ROW_BITS)) u_row_dec (
    .en (ce),
    .row(row_sel),
    .wl (wl)
  );

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] row_d;
  logic [WORD_W-1:0] rd_word;

  // Raised wordline connects its row onto the shared bitlines.
  always_comb begin
    row_q = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (wl[r]) row_q = row_q | mem[r];
    end
  end

  sram_col_path #(.WORD_W(WORD_W), .COL_BITS(COL_BITS)) u_col (
    .row_q  (row_q),
    .col    (col_sel),
    .wdata  (wdata),
    .rd_word(rd_word),
    .row_d  (row_d)
  );

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (access_wr && wl[r]) mem[r] <= row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata <= '0;
    else if (access_rd) rdata <= rd_word;
  end

  // R5
  one_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |-> ($countones(wl) == 1));

  // R6
  precharge_no_wl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> ($countones(wl) == 0));

  // R6 R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !access_rd |=> $stable(rdata));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (rdata == '0));

  // R4
  write_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_wr |-> ($countones(row_d ^ row_q) <= WORD_W));

endmodule

// File: tb/sram_folded_test.sv
`timescale 1ns/1ps
module sram_folded_test;
  localparam int unsigned AW = 11;
  localparam int unsigned DW = 16;
  localparam int unsigned WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [WORDS];

  always #2.5 clk = ~clk;

  sram_folded uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [DW-1:0] pat(input int unsigned a);
    return DW'((a * 16'h9E37) ^ 16'h5A5A ^ (a >> 3));
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [DW-1:0] d);
    @(negedge clk);
    ce = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    ce = 1'b0; we = 1'b0;
    model[a] = d;
  endtask

  task automatic rd(input string req, input int unsigned a);
    @(negedge clk);
    ce = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    ce = 1'b0;
    check(req, rdata, model[a]);
  endtask

  // R1: reset value
  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 during reset", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rdata, '0);
  endtask

  // R3: fill every address
  task automatic t_fill;
    for (int a = 0; a < int'(WORDS); a++) wr(a, pat(a));
    rd("R3 readback", 100);
  endtask

  // R2 R5: every address returns its own word
  task automatic t_read_all;
    for (int a = 0; a < int'(WORDS); a++) rd("R2 R5 full sweep", a);
  endtask

  // R4: write in mid-row, check row and column neighbours
  task automatic t_neighbours;
    int unsigned base = (37 << 3);
    wr(base + 5, 16'hC3A5);
    for (int c = 0; c < 8; c++) rd("R4 same row", base + c);
    rd("R4 row above", base - 8 + 5);
    rd("R4 row below", base + 8 + 5);
    wr(base + 2, 16'h0000);
    rd("R4 second word", base + 2);
    rd("R4 first word kept", base + 5);
  endtask

  // R6: disabled cycle with write enable stores nothing, rdata holds
  task automatic t_idle;
    logic [DW-1:0] held;
    rd("R6 setup", 500);
    held = rdata;
    @(negedge clk);
    ce = 1'b0; we = 1'b1; addr = AW'(501); wdata = ~model[501];
    @(negedge clk);
    we = 1'b0;
    check("R6 rdata held", rdata, held);
    rd("R6 no store", 501);
  endtask

  // R7: write does not disturb rdata
  task automatic t_write_hold;
    logic [DW-1:0] held;
    rd("R7 setup", 900);
    held = rdata;
    wr(901, 16'hBEEF);
    check("R7 rdata after write", rdata, held);
    rd("R7 new word", 901);
  endtask

  // R8: address extremes
  task automatic t_bounds;
    wr(0, 16'hFFFF);
    wr(WORDS - 1, 16'h8001);
    rd("R8 addr 0", 0);
    rd("R8 addr max", WORDS - 1);
    rd("R8 addr 1", 1);
    rd("R8 addr max-1", WORDS - 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_read_all();
    t_neighbours();
    t_idle();
    t_write_hold();
    t_bounds();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule